// File: doc/BRIEF.md
# SMBus Indexed Block Register Slave

This block is an SMBus slave that holds a bank of 8-bit control registers for a clock generator. The host reaches it through indexed block transfers. A write carries a starting index, then a byte count, then that many data bytes, which land in consecutive registers. A read first sets the index with a short write, then issues a repeated start with the read address. The slave answers with a byte count taken from a writable register, followed by register contents from the index upward, until the host NACKs.

SCL and SDA are oversampled on the system clock. They pass through a small synchronizer that also detects start and stop conditions. The slave pulls SDA low through a drive-low enable, and never drives it high. Every register bit is also presented in parallel on a flat vector for the clock control logic next to it.

A few fields are fixed identification values or locked bits and cannot be changed. Indices past the last implemented register are accepted on writes but leave nothing behind.

Top module: `smb_regbank`

## Requirements
- R1: After reset, register 1 and register 2 read 0xFF, register 6 reads 0x81, register 7 reads 0x01, register 8 (the read-back count) reads 0x09, and every other register reads 0x00. The slave does not pull SDA low.
- R2: The 7-bit address 0x69 is acknowledged in both directions: 0xD2 selects write and 0xD3 selects read. Any other address byte is not acknowledged. The slave then ignores all traffic until the next start condition, and no register changes.
- R3: On a write, the first byte after the address is the starting index and the second is the byte count. The data bytes that follow are stored in registers index, index+1, and so on. Every one of these bytes is acknowledged.
- R4: Once the byte count is used up, any further data byte is not acknowledged and does not change any register.
- R5: After the read address, the slave sends first the value of register 8, then the registers starting at the stored index in increasing order, one byte per host ACK. Bytes are sent MSB first. After a host NACK the slave releases SDA.
- R6: Register 8 is writable, and the value written is the count byte returned at the start of later reads.
- R7: Register 6 (0x81) and register 7 (0x01) are fully read-only. Bit 7 of register 14, bit 7 of register 18 and bits 7:4 of register 20 are read-only zeros. Writes to these bits have no effect.
- R8: Data bytes addressed at index 22 or above are acknowledged and discarded. Reads at those indices return 0x00.
- R9: A stop condition in the middle of a byte discards the partial byte and returns the slave to idle, with no register change. A start condition in the middle of a byte discards it and begins a new address phase.
- R10: Register i appears on regs_o bits [8i+7:8i] as soon as it has been written.
- R11: The slave changes its SDA drive only after it has detected a falling SCL edge, or a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_drive_low_o | output | 1 | When high, the pad pulls SDA low |
| regs_o | output | NUM_REGS*8 | Parallel view of all registers, register i at bits [8i+7:8i] |

## Verification
The assertions check on every cycle that the SDA drive moves only after an SCL fall or a bus condition, and that register writes happen only on an SCL fall. They also check that a stop releases SDA and leaves the slave idle, that a mismatched address is never acknowledged, and that the identification and locked bits never change. The bench scenarios are needed for the parts that span whole transactions. These are the index and count sequencing, NACK after the count is used up, the count byte and data order on reads, discarding of out-of-range indices, and recovery after a transfer cut off in the middle of a byte.

// File: rtl/smb_regbank_pkg.sv
package smb_regbank_pkg;

    localparam int REG_W       = 8;
    localparam int CNT_REG_IDX = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_HACK,
        PH_WAIT
    } phase_e;

    typedef enum logic [1:0] {
        ROLE_ADDR,
        ROLE_INDEX,
        ROLE_COUNT,
        ROLE_DATA
    } role_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic sda_hi;
        logic start;
        logic stop;
    } line_ev_t;

    // Power-up contents of each register slot.
    function automatic logic [REG_W-1:0] reg_reset_value(input int idx);
        case (idx)
            1, 2:    return 8'hFF;
            6:       return 8'h81;
            7:       return 8'h01;
            8:       return 8'h09;
            default: return 8'h00;
        endcase
    endfunction

    // Bits that keep their reset value no matter what the host writes.
    function automatic logic [REG_W-1:0] reg_ro_mask(input int idx);
        case (idx)
            6, 7:    return 8'hFF;
            14, 18:  return 8'h80;
            20:      return 8'hF0;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_regbank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] scl_q;
    logic [DEPTH-1:0] sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[DEPTH-2:0], scl_i};
            sda_q <= {sda_q[DEPTH-2:0], sda_i};
        end
    end

    logic scl_now, scl_prev, sda_now, sda_prev;

    always_comb begin
        scl_now     = scl_q[DEPTH-2];
        scl_prev    = scl_q[DEPTH-1];
        sda_now     = sda_q[DEPTH-2];
        sda_prev    = sda_q[DEPTH-1];
        ev.scl_rise = scl_now & ~scl_prev;
        ev.scl_fall = ~scl_now & scl_prev;
        ev.sda_hi   = sda_now;
        ev.start    = scl_now & scl_prev & ~sda_now & sda_prev;
        ev.stop     = scl_now & scl_prev & sda_now & ~sda_prev;
    end

endmodule

// File: rtl/smb_reg_file.sv
module smb_reg_file
    import smb_regbank_pkg::*;
#(
    parameter int NUM_REGS = 22,
    parameter int IDX_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [REG_W-1:0]          wr_data,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [REG_W-1:0]          rd_data,
    output logic [NUM_REGS*REG_W-1:0] regs_o
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [REG_W-1:0] RST_V = reg_reset_value(g);
        localparam logic [REG_W-1:0] RO_M  = reg_ro_mask(g);
        logic [REG_W-1:0] val_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= RST_V;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                val_q <= (wr_data & ~RO_M) | (RST_V & RO_M);
            end
        end

        assign regs_o[g*REG_W +: REG_W] = val_q;
    end

    // Indices past the bank match nothing and read as zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = regs_o[i*REG_W +: REG_W];
        end
    end

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
    import smb_regbank_pkg::*;
#(
    parameter int         NUM_REGS    = 22,
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      sda_drive_low_o,
    output logic [NUM_REGS*REG_W-1:0] regs_o
);
    localparam int IDX_W = REG_W;
    localparam int BIT_W = $clog2(REG_W + 1);
    localparam logic [BIT_W-1:0] FULL = BIT_W'(REG_W);

    line_ev_t         ev;
    phase_e           phase;
    role_e            role;
    logic [BIT_W-1:0] bitcnt;
    logic [REG_W-1:0] shreg;
    logic [IDX_W-1:0] idx;
    logic [REG_W-1:0] remain;
    logic             rd_mode;
    logic             host_ack;
    logic             ack_byte;
    logic             byte_end;
    logic             wr_en;
    logic [REG_W-1:0] rd_data;
    logic [REG_W-1:0] cnt_val;

    smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    smb_reg_file #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (shreg),
        .rd_idx  (idx),
        .rd_data (rd_data),
        .regs_o  (regs_o)
    );

    assign cnt_val = regs_o[CNT_REG_IDX*REG_W +: REG_W];

    // Decision taken on the SCL fall that closes a received byte.
    always_comb begin
        byte_end = (phase == PH_RX) && (bitcnt == FULL) && ev.scl_fall
                   && !ev.start && !ev.stop;
        case (role)
            ROLE_ADDR: ack_byte = (shreg[REG_W-1:1] == DEV_ADDR);
            ROLE_DATA: ack_byte = (remain != '0);
            default:   ack_byte = 1'b1;
        endcase
        wr_en = byte_end && (role == ROLE_DATA) && (remain != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase           <= PH_IDLE;
            role            <= ROLE_ADDR;
            bitcnt          <= '0;
            shreg           <= '0;
            idx             <= '0;
            remain          <= '0;
            rd_mode         <= 1'b0;
            host_ack        <= 1'b0;
            sda_drive_low_o <= 1'b0;
        end else if (ev.start) begin
            phase           <= PH_RX;
            role            <= ROLE_ADDR;
            bitcnt          <= '0;
            remain          <= '0;
            sda_drive_low_o <= 1'b0;
        end else if (ev.stop) begin
            phase           <= PH_IDLE;
            bitcnt          <= '0;
            sda_drive_low_o <= 1'b0;
        end else begin
            case (phase)
                PH_RX: begin
                    if (ev.scl_rise && bitcnt != FULL) begin
                        shreg  <= {shreg[REG_W-2:0], ev.sda_hi};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_end) begin
                        bitcnt <= '0;
                        if (ack_byte) begin
                            phase           <= PH_ACK;
                            sda_drive_low_o <= 1'b1;
                            case (role)
                                ROLE_ADDR: begin
                                    rd_mode <= shreg[0];
                                    role    <= ROLE_INDEX;
                                end
                                ROLE_INDEX: begin
                                    idx  <= shreg;
                                    role <= ROLE_COUNT;
                                end
                                ROLE_COUNT: begin
                                    remain <= shreg;
                                    role   <= ROLE_DATA;
                                end
                                default: begin
                                    idx    <= idx + 1'b1;
                                    remain <= remain - 1'b1;
                                end
                            endcase
                        end else begin
                            phase           <= PH_WAIT;
                            sda_drive_low_o <= 1'b0;
                        end
                    end
                end
                PH_ACK: begin
                    if (ev.scl_fall) begin
                        bitcnt <= '0;
                        if (rd_mode) begin
                            phase           <= PH_TX;
                            shreg           <= cnt_val;
                            sda_drive_low_o <= ~cnt_val[REG_W-1];
                        end else begin
                            phase           <= PH_RX;
                            sda_drive_low_o <= 1'b0;
                        end
                    end
                end
                PH_TX: begin
                    if (ev.scl_rise) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (ev.scl_fall) begin
                        if (bitcnt == FULL) begin
                            phase           <= PH_HACK;
                            sda_drive_low_o <= 1'b0;
                        end else begin
                            shreg           <= {shreg[REG_W-2:0], 1'b0};
                            sda_drive_low_o <= ~shreg[REG_W-2];
                        end
                    end
                end
                PH_HACK: begin
                    if (ev.scl_rise) begin
                        host_ack <= ~ev.sda_hi;
                    end else if (ev.scl_fall) begin
                        if (host_ack) begin
                            phase           <= PH_TX;
                            bitcnt          <= '0;
                            shreg           <= rd_data;
                            sda_drive_low_o <= ~rd_data[REG_W-1];
                            idx             <= idx + 1'b1;
                        end else begin
                            phase <= PH_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/smb_regbank_chk.sv
module smb_regbank_chk
    import smb_regbank_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input logic       clk,
    input logic       rst,
    input line_ev_t   ev,
    input logic       sda_low,
    input logic       wr_en,
    input phase_e     phase,
    input role_e      role,
    input logic [3:0] bitcnt,
    input logic [7:0] rx_byte,
    input logic [7:0] cnt_byte,
    input logic [7:0] id_byte,
    input logic       lock14,
    input logic       lock18,
    input logic [3:0] hi20
);
    logic bus_evt;
    assign bus_evt = ev.scl_fall | ev.start | ev.stop;

    // R11: SDA drive follows only a falling SCL or a bus condition
    p_sda_moves_after_fall_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_low) |-> $past(bus_evt));

    // R3: a register write is committed on the SCL fall closing a byte
    p_write_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ev.scl_fall);

    // R9: a stop condition releases SDA and idles the slave
    p_stop_idles_r9: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (!sda_low && phase == PH_IDLE));

    // R2: a foreign address byte is never acknowledged
    p_foreign_addr_nack_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RX && role == ROLE_ADDR && bitcnt == 4'd8 && ev.scl_fall
         && !ev.start && !ev.stop && rx_byte[7:1] != DEV_ADDR) |=> !sda_low);

    // R7: identification and locked bits hold their values
    p_locked_bits_r7: assert property (@(posedge clk) disable iff (rst)
        id_byte == 8'h81 && !lock14 && !lock18 && hi20 == 4'h0);

    // R1: count register leaves reset at nine
    p_count_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> cnt_byte == 8'h09);

endmodule

bind smb_regbank smb_regbank_chk #(.DEV_ADDR(DEV_ADDR)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev),
    .sda_low  (sda_drive_low_o),
    .wr_en    (wr_en),
    .phase    (phase),
    .role     (role),
    .bitcnt   (bitcnt),
    .rx_byte  (shreg),
    .cnt_byte (regs_o[64 +: 8]),
    .id_byte  (regs_o[48 +: 8]),
    .lock14   (regs_o[119]),
    .lock18   (regs_o[151]),
    .hi20     (regs_o[164 +: 4])
);

// File: tb/smb_regbank_tb.sv
module smb_regbank_tb;

    localparam int NREG = 22;
    localparam int Q    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_drv = 1'b1;
    logic sda_pull = 1'b0;
    logic dut_low;
    logic sda_line;
    logic [NREG*8-1:0] regs;

    always #4 clk = ~clk;

    assign sda_line = ~(sda_pull | dut_low);

    smb_regbank u_dut (
        .clk             (clk),
        .rst             (rst),
        .scl_i           (scl_drv),
        .sda_i           (sda_line),
        .sda_drive_low_o (dut_low),
        .regs_o          (regs)
    );

    typedef struct {
        logic [7:0] v;
        string      tag;
    } sb_item_t;

    sb_item_t   exp_q[$];
    logic [7:0] act_q[$];
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rv(input int i);
        return regs[i*8 +: 8];
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    // Scoreboard monitor: compares read bytes against expectations.
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0) begin
                sb_item_t e;
                logic [7:0] a;
                a = act_q.pop_front();
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_err++;
                    $display("FAIL R5 unexpected byte: actual %0h expected none", a);
                end else begin
                    e = exp_q.pop_front();
                    if (a !== e.v) begin
                        n_err++;
                        $display("FAIL %s: actual %0h expected %0h", e.tag, a, e.v);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_pull = 1'b0; wq();
        scl_drv  = 1'b1; wq();
        sda_pull = 1'b1; wq();
        scl_drv  = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_pull = 1'b1; wq();
        scl_drv  = 1'b1; wq();
        sda_pull = 1'b0; wq();
    endtask

    task automatic xbit(input logic b, output logic r);
        sda_pull = ~b; wq();
        scl_drv  = 1'b1; wq();
        r = sda_line; wq();
        scl_drv  = 1'b0; wq();
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) xbit(b[i], r);
        xbit(1'b1, r);
        ack = ~r;
    endtask

    task automatic rbyte(input logic give_ack);
        logic r;
        logic [7:0] b;
        for (int i = 7; i >= 0; i--) begin
            xbit(1'b1, r);
            b[i] = r;
        end
        act_q.push_back(b);
        xbit(~give_ack, r);
    endtask

    task automatic wr_hdr(input logic [7:0] idx, input logic [7:0] cnt);
        logic a;
        bus_start();
        wbyte(8'hD2, a); chk("R2 write address ack", a, 1);
        wbyte(idx, a);   chk("R3 index ack", a, 1);
        wbyte(cnt, a);   chk("R3 count ack", a, 1);
    endtask

    task automatic wr_one(input logic [7:0] idx, input logic [7:0] d);
        logic a;
        wr_hdr(idx, 8'd1);
        wbyte(d, a); chk("R3 data ack", a, 1);
        bus_stop();
    endtask

    task automatic rd_block(input logic [7:0] idx, input int n);
        logic a;
        bus_start();
        wbyte(8'hD2, a); chk("R2 write address ack", a, 1);
        wbyte(idx, a);   chk("R5 index ack", a, 1);
        bus_start();
        wbyte(8'hD3, a); chk("R2 read address ack", a, 1);
        for (int i = 0; i < n; i++) rbyte(i != n - 1);
        wq();
        chk("R5 SDA released after host NACK", dut_low, 0);
        bus_stop();
        wq();
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        sb_item_t it;
        it.v = v;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    initial begin
        logic a;
        logic r;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 reg0", rv(0), 8'h00);
        chk("R1 reg1", rv(1), 8'hFF);
        chk("R1 reg2", rv(2), 8'hFF);
        chk("R1 reg6", rv(6), 8'h81);
        chk("R1 reg7", rv(7), 8'h01);
        chk("R1 reg8", rv(8), 8'h09);
        chk("R1 SDA idle", dut_low, 0);

        // R3 / R10 block write of three bytes
        wr_hdr(8'd0, 8'd3);
        wbyte(8'h11, a); chk("R3 data0 ack", a, 1);
        wbyte(8'h22, a); chk("R3 data1 ack", a, 1);
        wbyte(8'h33, a); chk("R3 data2 ack", a, 1);
        bus_stop();
        chk("R10 reg0 view", rv(0), 8'h11);
        chk("R10 reg1 view", rv(1), 8'h22);
        chk("R10 reg2 view", rv(2), 8'h33);

        // R5 block read: count byte first then data
        expect_byte(8'h09, "R5 count byte");
        expect_byte(8'h11, "R5 reg0");
        expect_byte(8'h22, "R5 reg1");
        expect_byte(8'h33, "R5 reg2");
        rd_block(8'd0, 4);

        // R6 writable count register
        wr_one(8'd8, 8'h02);
        chk("R6 reg8 view", rv(8), 8'h02);
        expect_byte(8'h02, "R6 count byte follows reg8");
        expect_byte(8'h22, "R5 reg1 second read");
        expect_byte(8'h33, "R5 reg2 second read");
        rd_block(8'd1, 3);

        // R7 read-only bits
        wr_one(8'd6, 8'h00);
        chk("R7 reg6 fixed", rv(6), 8'h81);
        wr_one(8'd14, 8'hFF);
        chk("R7 reg14 bit7 locked", rv(14), 8'h7F);
        wr_one(8'd18, 8'hFF);
        chk("R7 reg18 bit7 locked", rv(18), 8'h7F);
        wr_one(8'd20, 8'hFF);
        chk("R7 reg20 upper nibble locked", rv(20), 8'h0F);
        expect_byte(8'h02, "R7 count byte");
        expect_byte(8'h81, "R7 device id");
        expect_byte(8'h01, "R7 vendor byte");
        rd_block(8'd6, 3);

        // R2 foreign address is ignored
        bus_start();
        wbyte(8'hA4, a); chk("R2 foreign address nack", a, 0);
        wbyte(8'h00, a); chk("R2 ignored index nack", a, 0);
        wbyte(8'h01, a); chk("R2 ignored count nack", a, 0);
        wbyte(8'h5A, a); chk("R2 ignored data nack", a, 0);
        bus_stop();
        chk("R2 reg0 unchanged", rv(0), 8'h11);

        // R8 indices beyond the bank
        wr_hdr(8'd21, 8'd3);
        wbyte(8'h3C, a); chk("R8 last reg ack", a, 1);
        wbyte(8'h44, a); chk("R8 out-of-range ack", a, 1);
        wbyte(8'h55, a); chk("R8 out-of-range ack 2", a, 1);
        bus_stop();
        chk("R8 reg21 written", rv(21), 8'h3C);
        chk("R8 reg0 untouched by wrap", rv(0), 8'h11);
        expect_byte(8'h02, "R8 count byte");
        expect_byte(8'h0F, "R8 reg20");
        expect_byte(8'h3C, "R8 reg21");
        expect_byte(8'h00, "R8 index 22 reads zero");
        expect_byte(8'h00, "R8 index 23 reads zero");
        rd_block(8'd20, 5);

        // R4 bytes past the count
        wr_hdr(8'd3, 8'd1);
        wbyte(8'h77, a); chk("R4 counted byte ack", a, 1);
        wbyte(8'h88, a); chk("R4 excess byte nack", a, 0);
        bus_stop();
        chk("R4 reg3 written", rv(3), 8'h77);
        chk("R4 reg4 untouched", rv(4), 8'h00);

        // R9 stop in the middle of a data byte
        wr_hdr(8'd9, 8'd1);
        xbit(1'b1, r); xbit(1'b0, r); xbit(1'b1, r); xbit(1'b0, r);
        bus_stop();
        wq();
        chk("R9 stop abort leaves reg9", rv(9), 8'h00);
        chk("R9 stop abort releases SDA", dut_low, 0);
        wr_one(8'd9, 8'h66);
        chk("R9 write after abort", rv(9), 8'h66);

        // R9 start in the middle of a byte begins a new address phase
        bus_start();
        xbit(1'b1, r); xbit(1'b1, r); xbit(1'b0, r);
        bus_start();
        wbyte(8'hD2, a); chk("R9 address ack after restart", a, 1);
        wbyte(8'd10, a); chk("R9 index ack after restart", a, 1);
        wbyte(8'd1, a);  chk("R9 count ack after restart", a, 1);
        wbyte(8'h99, a); chk("R9 data ack after restart", a, 1);
        bus_stop();
        chk("R9 reg10 after restart", rv(10), 8'h99);

        repeat (20) @(negedge clk);
        chk("R5 all expected bytes returned", exp_q.size(), 0);
        summary();
    end

endmodule